// File: doc/BRIEF.md
# Brown-Out Reset Sequencer

This block is the digital controller that sits behind an analog supply comparator. The comparator reports when the supply has fallen below its threshold. The controller first passes that flag through a two-stage synchroniser. It then ignores dips shorter than a programmable filter time. When a real brown-out occurs, it requests a chip reset and keeps that request asserted while the supply stays low. Once the supply recovers it can optionally stretch the reset with a power-up delay. A further dip during that delay sends it back to the held state and restarts the delay from zero.

A 2-bit configuration input decides when detection is armed. The four choices are: never; under firmware control through a software enable bit; by hardware except while the chip sleeps; and by hardware at all times. A status flag that firmware can read drops to 0 on every brown-out or power-on event, and a write strobe sets it back to 1. The software enable is read back through its own output, and that output is forced to 0 in every configuration except the firmware-controlled one. A power-on reset input returns the controller to idle and asserts the reset request while it is held.

Top module: `brownout_ctl`

## Requirements
- R1: Configuration 2'b00 disables detection: no dip of any length raises `rst_req_o`.
- R2: Configuration 2'b01 arms detection only while `sw_en_i` is 1.
- R3: `sw_en_rd_o` equals `sw_en_i` in configuration 2'b01 and is 0 in every other configuration.
- R4: Configuration 2'b10 arms detection while `sleep_i` is 0 and disarms it while `sleep_i` is 1.
- R5: Configuration 2'b11 arms detection regardless of `sw_en_i` and `sleep_i`.
- R6: While armed, a dip of `supply_low_i` lasting FILT_CYC clock cycles or less causes no reset. A dip of FILT_CYC+1 cycles or more raises `rst_req_o` FILT_CYC+2 cycles after the first low sample.
- R7: Once raised, `rst_req_o` stays high for as long as the synchronised low flag stays high.
- R8: With `pwrup_en_i` = 1, `rst_req_o` falls PWRUP_CYC+2 cycles after `supply_low_i` returns to 0. A new dip during the delay returns the block to the held state and restarts the full delay.
- R9: With `pwrup_en_i` = 0, `rst_req_o` falls 2 cycles after `supply_low_i` returns to 0, whatever the detection configuration.
- R10: `flag_o` is 0 during and after a power-on reset and is cleared on every brown-out trip. A `flag_set_i` pulse sets it to 1, and a dip that does not trip leaves it at 1.
- R11: While `por_i` is high, `rst_req_o` is 1 and the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| supply_low_i | input | 1 | Comparator output, 1 when the supply is below threshold (asynchronous) |
| mode_i | input | 2 | Detection configuration: 00 off, 01 firmware, 10 hardware except sleep, 11 hardware always |
| sw_en_i | input | 1 | Firmware detection enable |
| sleep_i | input | 1 | 1 while the chip is in its sleep state |
| pwrup_en_i | input | 1 | Enables the power-up delay after recovery |
| flag_set_i | input | 1 | Firmware write strobe that sets the status flag |
| rst_req_o | output | 1 | Chip reset request |
| flag_o | output | 1 | Brown-out status flag, 0 after any trip or power-on reset |
| sw_en_rd_o | output | 1 | Readback of the firmware enable |

## Verification
The hardest situation to reach from the ports is a second dip that lands inside the power-up delay. The bench first holds a long dip, then releases it and waits a few cycles until the delay counter is partly advanced. It then applies a one-cycle pulse on `supply_low_i`. The reset length it measures from that pulse must equal the full delay, not the remainder. Filter boundaries are covered by a sweep of every configuration, enable and sleep combination against dips of exactly FILT_CYC and FILT_CYC+1 cycles.

// File: rtl/brownout_pkg.sv
package brownout_pkg;
  typedef enum logic [1:0] {
    CFG_OFF     = 2'b00,
    CFG_FW      = 2'b01,
    CFG_HW_WAKE = 2'b10,
    CFG_HW_ON   = 2'b11
  } bo_cfg_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_HOLD  = 2'b01,
    ST_DELAY = 2'b10
  } bo_state_e;
endpackage

// File: rtl/bo_sync.sv
module bo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or posedge por_i) begin
          if (por_i) chain[0] <= 1'b0;
          else       chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or posedge por_i) begin
          if (por_i) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bo_enable_dec.sv
module bo_enable_dec
  import brownout_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       sw_en_i,
  input  logic       sleep_i,
  output logic       armed_o,
  output logic       sw_rd_o
);
  bo_cfg_e cfg;
  assign cfg = bo_cfg_e'(mode_i);

  always_comb begin
    armed_o = 1'b0;
    sw_rd_o = 1'b0;
    unique case (cfg)
      CFG_OFF:     armed_o = 1'b0;
      CFG_FW: begin
        armed_o = sw_en_i;
        sw_rd_o = sw_en_i;
      end
      CFG_HW_WAKE: armed_o = ~sleep_i;
      CFG_HW_ON:   armed_o = 1'b1;
      default:     armed_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bo_fsm.sv
module bo_fsm
  import brownout_pkg::*;
#(
  parameter int FILT_CYC  = 200,
  parameter int PWRUP_CYC = 65536,
  parameter int CW        = 17
) (
  input  logic          clk_i,
  input  logic          por_i,
  input  logic          low_i,
  input  logic          armed_i,
  input  logic          pwrup_en_i,
  output bo_state_e     st_o,
  output logic [CW-1:0] cnt_o,
  output logic          trip_o
);
  localparam logic [CW-1:0] FILT_LIM  = CW'(FILT_CYC);
  localparam logic [CW-1:0] PWRUP_LIM = CW'(PWRUP_CYC - 1);

  bo_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (armed_i && low_i) begin
          if (cnt_q == FILT_LIM) begin
            st_d  = ST_HOLD;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          cnt_d = '0;
        end
      end
      ST_HOLD: begin
        cnt_d = '0;
        if (!low_i) st_d = pwrup_en_i ? ST_DELAY : ST_IDLE;
      end
      ST_DELAY: begin
        if (low_i) begin
          st_d  = ST_HOLD;
          cnt_d = '0;
        end else if (cnt_q == PWRUP_LIM) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o   = st_q;
  assign cnt_o  = cnt_q;
  assign trip_o = (st_d == ST_HOLD) && (st_q != ST_HOLD);
endmodule

// File: rtl/brownout_ctl.sv
module brownout_ctl
  import brownout_pkg::*;
#(
  parameter int FILT_CYC    = 200,
  parameter int PWRUP_CYC   = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       supply_low_i,
  input  logic [1:0] mode_i,
  input  logic       sw_en_i,
  input  logic       sleep_i,
  input  logic       pwrup_en_i,
  input  logic       flag_set_i,
  output logic       rst_req_o,
  output logic       flag_o,
  output logic       sw_en_rd_o
);
  localparam int MAXC = (FILT_CYC > PWRUP_CYC) ? FILT_CYC : PWRUP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          low_s;
  logic          armed;
  bo_state_e     st;
  logic [CW-1:0] cnt;
  logic          trip;
  logic          flag_q;

  bo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .por_i (por_i),
    .d_i   (supply_low_i),
    .q_o   (low_s)
  );

  bo_enable_dec u_dec (
    .mode_i  (mode_i),
    .sw_en_i (sw_en_i),
    .sleep_i (sleep_i),
    .armed_o (armed),
    .sw_rd_o (sw_en_rd_o)
  );

  bo_fsm #(
    .FILT_CYC  (FILT_CYC),
    .PWRUP_CYC (PWRUP_CYC),
    .CW        (CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .low_i      (low_s),
    .armed_i    (armed),
    .pwrup_en_i (pwrup_en_i),
    .st_o       (st),
    .cnt_o      (cnt),
    .trip_o     (trip)
  );

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)           flag_q <= 1'b0;
    else if (trip)       flag_q <= 1'b0;
    else if (flag_set_i) flag_q <= 1'b1;
  end

  assign flag_o    = flag_q;
  assign rst_req_o = por_i | (st == ST_HOLD) | (st == ST_DELAY);
endmodule

// File: rtl/bo_ctl_chk.sv
module bo_ctl_chk
  import brownout_pkg::*;
#(
  parameter int FILT_CYC = 200,
  parameter int CW       = 17
) (
  input logic          clk_i,
  input logic          por_i,
  input logic [1:0]    mode_i,
  input logic          pwrup_en_i,
  input logic          rst_req_o,
  input logic          flag_o,
  input logic          sw_en_rd_o,
  input logic          low_s,
  input bo_state_e     st,
  input logic [CW-1:0] cnt
);
  p_swrd_only_fw_r3: assert property (@(posedge clk_i) disable iff (por_i)
    sw_en_rd_o |-> (mode_i == 2'b01));

  p_off_no_count_r1: assert property (@(posedge clk_i) disable iff (por_i)
    $past(mode_i == 2'b00 && st == ST_IDLE) |-> (cnt == '0));

  p_trip_after_filter_r6: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(rst_req_o) |-> ($past(st) == ST_IDLE && $past(cnt) == CW'(FILT_CYC)));

  p_hold_while_low_r7: assert property (@(posedge clk_i) disable iff (por_i)
    (st == ST_HOLD && low_s) |=> (st == ST_HOLD));

  p_delay_restart_r8: assert property (@(posedge clk_i) disable iff (por_i)
    (st == ST_DELAY && low_s) |=> (st == ST_HOLD));

  p_no_delay_release_r9: assert property (@(posedge clk_i) disable iff (por_i)
    (st == ST_HOLD && !low_s && !pwrup_en_i) |=> (st == ST_IDLE));

  p_flag_clear_on_trip_r10: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(rst_req_o) |-> !flag_o);
endmodule

bind brownout_ctl bo_ctl_chk #(.FILT_CYC(FILT_CYC), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .por_i      (por_i),
  .mode_i     (mode_i),
  .pwrup_en_i (pwrup_en_i),
  .rst_req_o  (rst_req_o),
  .flag_o     (flag_o),
  .sw_en_rd_o (sw_en_rd_o),
  .low_s      (low_s),
  .st         (st),
  .cnt        (cnt)
);

// File: tb/brownout_ctl_tb.sv
`timescale 1ns/1ps
module brownout_ctl_tb;
  localparam int FILT  = 4;
  localparam int PWRUP = 8;

  logic clk = 1'b0;
  logic por, supply_low, sw_en, sleep, pwrup_en, flag_set;
  logic [1:0] mode;
  logic rst_req, flag, sw_rd;
  logic saw_rst;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  brownout_ctl #(.FILT_CYC(FILT), .PWRUP_CYC(PWRUP)) u_dut (
    .clk_i(clk), .por_i(por), .supply_low_i(supply_low), .mode_i(mode),
    .sw_en_i(sw_en), .sleep_i(sleep), .pwrup_en_i(pwrup_en),
    .flag_set_i(flag_set), .rst_req_o(rst_req), .flag_o(flag),
    .sw_en_rd_o(sw_rd)
  );

  always @(negedge clk) if (rst_req) saw_rst <= 1'b1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dip(input int n);
    @(negedge clk);
    supply_low = 1'b1;
    repeat (n) @(negedge clk);
    supply_low = 1'b0;
  endtask

  task automatic set_flag();
    @(negedge clk); flag_set = 1'b1;
    @(negedge clk); flag_set = 1'b0;
  endtask

  function automatic bit armed_exp(input logic [1:0] m, input bit sw, input bit sl);
    case (m)
      2'b00: return 1'b0;
      2'b01: return sw;
      2'b10: return !sl;
      default: return 1'b1;
    endcase
  endfunction

  int run_len;
  task automatic measure_release();
    run_len = 0;
    forever begin
      @(negedge clk);
      if (rst_req) run_len++;
      else break;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    por = 1'b1; supply_low = 1'b0; mode = 2'b11; sw_en = 1'b0;
    sleep = 1'b0; pwrup_en = 1'b0; flag_set = 1'b0; saw_rst = 1'b0;
    idle(3);
    // R11: reset request during power-on reset; R10: flag cleared
    check("R11 rst during por", int'(rst_req), 1);
    check("R10 flag after por", int'(flag), 0);
    por = 1'b0;
    idle(3);
    check("R11 idle after por", int'(rst_req), 0);

    // R3: readback in every configuration
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        mode = 2'(m); sw_en = s[0];
        #1;
        check("R3 sw readback", int'(sw_rd), (m == 1) ? s : 0);
      end
    end

    // R1 R2 R4 R5 R6 R10: sweep of configurations against filter boundary
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int sl = 0; sl < 2; sl++) begin
          for (int len = FILT; len <= FILT + 1; len++) begin
            bit exp_trip;
            @(negedge clk);
            mode = 2'(m); sw_en = s[0]; sleep = sl[0]; pwrup_en = 1'b0;
            set_flag();
            idle(2);
            saw_rst = 1'b0;
            exp_trip = armed_exp(2'(m), s[0], sl[0]) && (len > FILT);
            dip(len);
            idle(FILT + 8);
            case (m)
              0: check("R1 R6 off config trip", int'(saw_rst), int'(exp_trip));
              1: check("R2 R6 fw config trip", int'(saw_rst), int'(exp_trip));
              2: check("R4 R6 sleep config trip", int'(saw_rst), int'(exp_trip));
              default: check("R5 R6 always config trip", int'(saw_rst), int'(exp_trip));
            endcase
            check("R10 flag after dip", int'(flag), int'(!exp_trip));
          end
        end
      end
    end

    // R6 latency / R7 hold: long dip in always-on config
    @(negedge clk);
    mode = 2'b11; sleep = 1'b1; sw_en = 1'b0; pwrup_en = 1'b0;
    idle(2);
    @(negedge clk);
    supply_low = 1'b1;
    begin
      int first_hi;
      first_hi = 0;
      for (int k = 1; k <= FILT + 6; k++) begin
        @(negedge clk);
        if (rst_req && first_hi == 0) first_hi = k;
      end
      check("R6 trip latency", first_hi, FILT + 3);
    end
    idle(20);
    check("R7 held while low", int'(rst_req), 1);
    // R9: release without delay
    supply_low = 1'b0;
    measure_release();
    check("R9 release without delay", run_len, 2);

    // R8: release with power-up delay
    @(negedge clk);
    pwrup_en = 1'b1;
    dip(FILT + 10);
    measure_release();
    check("R8 delay length", run_len, PWRUP + 2);

    // R8: dip inside the delay restarts it
    idle(3);
    dip(FILT + 10);
    idle(3);
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
    measure_release();
    check("R8 restart full delay", run_len, PWRUP + 2);

    // R9 in sleep-gated config with pwrup off
    @(negedge clk);
    mode = 2'b10; sleep = 1'b0; pwrup_en = 1'b0;
    dip(FILT + 5);
    measure_release();
    check("R9 release hw config", run_len, 2);

    // R10: flag set then cleared by power-on reset
    set_flag();
    check("R10 flag set", int'(flag), 1);
    @(negedge clk); por = 1'b1;
    #1;
    check("R10 flag por clear", int'(flag), 0);
    check("R11 rst during second por", int'(rst_req), 1);
    idle(2); por = 1'b0;
    idle(2);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule